// File: doc/BRIEF.md
# Directory Home Coherence Controller

This block is the home node of a directory-based coherence scheme for a small group of processor caches. For every memory block it owns, it tracks which caches hold a copy (one presence bit per cache), whether one cache holds a modified copy (the dirty flag), and a protocol state. It also holds the block's memory word in a small internal register file. Caches send it read and write requests. It answers with shared or exclusive data, sends invalidations to sharers, and recalls modified lines from their owner. It then collects invalidation acknowledgements and write-backs before it finishes a request.

Each cache port has three channels: a request channel with a ready signal, an acknowledgement/write-back channel that is always taken in priority order, and an outgoing message channel that pulses for one cycle. The block takes one action per cycle, so every port receives its messages in the order the home node produced them. While a block waits for acknowledgements or a write-back, new requests for that block are held at the port. Requests for other blocks go on as normal.

The configuration is four caches, four blocks and 8-bit data. After reset, block b holds the value 0x40 + b.

Top module: `coh_home`

## Requirements
- R1: After reset every block is uncached and clean, no message is valid, and block b's memory word is 0x40 + b.
- R2: A read of a clean block is accepted and, on the next cycle, sends kind 1 (shared data) with the memory word to the requester only. The requester is then added as a sharer.
- R3: A write to a clean block whose only possible sharer is the requester sends kind 2 (exclusive data) with the memory word to the requester on the next cycle. The requester becomes the sole owner.
- R4: A write to a clean block with other sharers sends kind 3 (invalidate) in one cycle to every other sharer, and to the requester not at all. The sharers' presence bits are cleared. Kind 2 is granted only in the cycle after the last invalidation acknowledgement (ack_wb=0) arrives. Earlier acknowledgements produce no message, and memory does not change while the block waits.
- R5: A read of an owned block sends kind 4 (recall, keep shared) to the owner only. The owner's write-back (ack_wb=1) updates memory and sends kind 1 with the written-back data to the requester. The block becomes clean with both the old owner and the requester as sharers.
- R6: A write to an owned block sends kind 5 (recall and invalidate) to the owner. On the write-back, kind 2 with the written-back data goes to the requester, which becomes the only cache present. A later recall of that block therefore targets only the new owner.
- R7: A request to a block that is waiting for acknowledgements or a write-back is not accepted (ready low). A request to another block is accepted in the same period.
- R8: At most one request is accepted per cycle. Any valid acknowledgement blocks all request acceptance in that cycle. Among eligible requests, the lowest port number wins.
- R9: Messages last exactly one cycle and appear only in the cycle after an accepted request or acknowledgement. An acknowledgement that does not match a waiting block is dropped with no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Request present, one bit per cache |
| req_write | input | 4 | 1 = write (exclusive) request, 0 = read |
| req_blk | input | 8 | Block index per port, 2 bits each, port 0 in the low bits |
| req_ready | output | 4 | Request accepted this cycle |
| ack_valid | input | 4 | Acknowledgement or write-back present |
| ack_wb | input | 4 | 1 = write-back carrying data, 0 = invalidation acknowledgement |
| ack_blk | input | 8 | Block index per port, 2 bits each |
| ack_data | input | 32 | Write-back data per port, 8 bits each |
| ack_ready | output | 4 | Acknowledgement taken this cycle |
| msg_valid | output | 4 | Outgoing message valid per port |
| msg_kind | output | 12 | Message kind per port, 3 bits each: 1 shared data, 2 exclusive data, 3 invalidate, 4 recall keep shared, 5 recall invalidate |
| msg_blk | output | 8 | Block index of the message per port |
| msg_data | output | 32 | Data of the message per port |

## Verification
The embedded assertions check the directory's invariants on every cycle: an owned block has exactly one presence bit and its dirty flag set, a clean block never carries the dirty flag, and a block waiting for invalidations has a non-zero count and an unchanging memory word. They also check that at most one request is taken per cycle, that acknowledgements block requests, and that every message has a cause. Only the bench's scenarios can show the protocol-level results. These are: which ports receive invalidations or recalls, that the grant waits for the last acknowledgement, that written-back data reaches the next reader and memory, that requests to a busy block are held while others proceed, and that a stray acknowledgement is dropped.

// File: rtl/coh_pkg.sv
package coh_pkg;

    parameter int NPROC = 4;
    parameter int NBLK  = 4;
    parameter int DW    = 8;

    localparam int BW = $clog2(NBLK);
    localparam int IW = $clog2(NPROC);
    localparam int CW = $clog2(NPROC + 1);
    localparam int KW = 3;

    typedef enum logic [KW-1:0] {
        K_NONE = 3'd0,
        K_DSH  = 3'd1,
        K_DEX  = 3'd2,
        K_INV  = 3'd3,
        K_RCS  = 3'd4,
        K_RCI  = 3'd5
    } kind_t;

    // shared/uncached, owned, waiting for invalidation acks, waiting for write-back
    typedef enum logic [1:0] {
        D_SHR  = 2'd0,
        D_OWN  = 2'd1,
        D_WINV = 2'd2,
        D_WREC = 2'd3
    } dstate_t;

    typedef struct packed {
        dstate_t          st;
        logic [NPROC-1:0] pres;
        logic             dirty;
        logic [CW-1:0]    cnt;
        logic [IW-1:0]    who;
        logic             wr;
        logic [DW-1:0]    data;
    } dent_t;

    function automatic logic [IW-1:0] oh2idx(input logic [NPROC-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < NPROC; i++)
            if (v[i]) r = r | IW'(i);
        return r;
    endfunction

    function automatic logic [NPROC-1:0] idx2oh(input logic [IW-1:0] i);
        return NPROC'(1) << i;
    endfunction

    function automatic logic [DW-1:0] boot_word(input int b);
        return DW'(64 + b);
    endfunction

    function automatic logic is_stable(input dstate_t s);
        return (s == D_SHR) || (s == D_OWN);
    endfunction

endpackage

// File: rtl/coh_prio_pick.sv
module coh_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [BW-1:0]     upd_blk,
    input  dent_t             upd_ent,
    output dent_t             ent [NBLK]
);
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[b].st    <= D_SHR;
                ent[b].pres  <= '0;
                ent[b].dirty <= 1'b0;
                ent[b].cnt   <= '0;
                ent[b].who   <= '0;
                ent[b].wr    <= 1'b0;
                ent[b].data  <= boot_word(b);
            end else if (upd_en && upd_blk == BW'(b)) begin
                ent[b] <= upd_ent;
            end
        end

        // an owned block names exactly one cache and is dirty
        assert_owner_single_R6: assert property (@(posedge clk) disable iff (rst)
            (ent[b].st == D_OWN) |-> ($countones(ent[b].pres) == 1 && ent[b].dirty));
        // a shared/uncached block is never dirty
        assert_clean_shared_R5: assert property (@(posedge clk) disable iff (rst)
            (ent[b].st == D_SHR) |-> !ent[b].dirty);
        // a block waiting for invalidations always expects at least one
        assert_tr_count_R4: assert property (@(posedge clk) disable iff (rst)
            (ent[b].st == D_WINV) |-> (ent[b].cnt != '0));
        // memory is untouched while invalidations are outstanding
        assert_mem_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (ent[b].st == D_WINV) |=> $stable(ent[b].data));
    end
endmodule

// File: rtl/coh_msg_reg.sv
module coh_msg_reg
    import coh_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NPROC-1:0]    in_mask,
    input  kind_t               in_kind,
    input  logic [BW-1:0]       in_blk,
    input  logic [DW-1:0]       in_data,
    output logic [NPROC-1:0]    msg_valid,
    output logic [NPROC*KW-1:0] msg_kind,
    output logic [NPROC*BW-1:0] msg_blk,
    output logic [NPROC*DW-1:0] msg_data
);
    logic [NPROC-1:0] mask_q;
    kind_t            kind_q;
    logic [BW-1:0]    blk_q;
    logic [DW-1:0]    data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            kind_q <= K_NONE;
            blk_q  <= '0;
            data_q <= '0;
        end else begin
            mask_q <= in_mask;
            kind_q <= in_kind;
            blk_q  <= in_blk;
            data_q <= in_data;
        end
    end

    assign msg_valid = mask_q;

    for (genvar p = 0; p < NPROC; p++) begin : g_port
        assign msg_kind[p*KW +: KW] = mask_q[p] ? kind_q : K_NONE;
        assign msg_blk [p*BW +: BW] = mask_q[p] ? blk_q  : '0;
        assign msg_data[p*DW +: DW] = mask_q[p] ? data_q : '0;
    end
endmodule

// File: rtl/coh_home.sv
module coh_home
    import coh_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NPROC-1:0]    req_valid,
    input  logic [NPROC-1:0]    req_write,
    input  logic [NPROC*BW-1:0] req_blk,
    output logic [NPROC-1:0]    req_ready,
    input  logic [NPROC-1:0]    ack_valid,
    input  logic [NPROC-1:0]    ack_wb,
    input  logic [NPROC*BW-1:0] ack_blk,
    input  logic [NPROC*DW-1:0] ack_data,
    output logic [NPROC-1:0]    ack_ready,
    output logic [NPROC-1:0]    msg_valid,
    output logic [NPROC*KW-1:0] msg_kind,
    output logic [NPROC*BW-1:0] msg_blk,
    output logic [NPROC*DW-1:0] msg_data
);
    dent_t            tbl [NBLK];
    logic [BW-1:0]    rblk [NPROC];
    logic [BW-1:0]    ablk [NPROC];
    logic [DW-1:0]    adat [NPROC];
    logic [NPROC-1:0] req_elig, req_pick, ack_gnt, req_gnt;

    logic             upd_en;
    logic [BW-1:0]    upd_blk;
    dent_t            upd_ent;
    logic [NPROC-1:0] o_mask;
    kind_t            o_kind;
    logic [BW-1:0]    o_blk;
    logic [DW-1:0]    o_data;

    always_comb begin
        for (int i = 0; i < NPROC; i++) begin
            rblk[i]     = req_blk[i*BW +: BW];
            ablk[i]     = ack_blk[i*BW +: BW];
            adat[i]     = ack_data[i*DW +: DW];
            req_elig[i] = req_valid[i] && is_stable(tbl[rblk[i]].st);
        end
    end

    coh_prio_pick #(.N(NPROC)) u_ack_pick (.req(ack_valid), .gnt(ack_gnt));
    coh_prio_pick #(.N(NPROC)) u_req_pick (.req(req_elig),  .gnt(req_pick));

    assign req_gnt   = (|ack_valid) ? '0 : req_pick;
    assign ack_ready = ack_gnt;
    assign req_ready = req_gnt;

    always_comb begin
        dent_t            cur;
        logic [IW-1:0]    a_id, r_id;
        logic [NPROC-1:0] others;
        a_id    = oh2idx(ack_gnt);
        r_id    = oh2idx(req_gnt);
        upd_en  = 1'b0;
        upd_blk = '0;
        cur     = tbl[0];
        upd_ent = cur;
        others  = '0;
        o_mask  = '0;
        o_kind  = K_NONE;
        o_blk   = '0;
        o_data  = '0;
        if (|ack_gnt) begin
            upd_blk = ablk[a_id];
            cur     = tbl[upd_blk];
            upd_ent = cur;
            o_blk   = upd_blk;
            if (cur.st == D_WINV && !ack_wb[a_id]) begin
                upd_en = 1'b1;
                if (cur.cnt == CW'(1)) begin
                    upd_ent.st    = D_OWN;
                    upd_ent.dirty = 1'b1;
                    upd_ent.pres  = idx2oh(cur.who);
                    upd_ent.cnt   = '0;
                    o_mask = idx2oh(cur.who);
                    o_kind = K_DEX;
                    o_data = cur.data;
                end else begin
                    upd_ent.cnt = cur.cnt - CW'(1);
                end
            end else if (cur.st == D_WREC && ack_wb[a_id] && cur.pres[a_id]) begin
                upd_en       = 1'b1;
                upd_ent.data = adat[a_id];
                o_mask       = idx2oh(cur.who);
                o_data       = adat[a_id];
                if (cur.wr) begin
                    upd_ent.st    = D_OWN;
                    upd_ent.dirty = 1'b1;
                    upd_ent.pres  = idx2oh(cur.who);
                    o_kind        = K_DEX;
                end else begin
                    upd_ent.st    = D_SHR;
                    upd_ent.dirty = 1'b0;
                    upd_ent.pres  = cur.pres | idx2oh(cur.who);
                    o_kind        = K_DSH;
                end
            end
        end else if (|req_gnt) begin
            upd_en  = 1'b1;
            upd_blk = rblk[r_id];
            cur     = tbl[upd_blk];
            upd_ent = cur;
            o_blk   = upd_blk;
            o_data  = cur.data;
            if (cur.st == D_SHR) begin
                if (!req_write[r_id]) begin
                    upd_ent.pres = cur.pres | idx2oh(r_id);
                    o_mask = idx2oh(r_id);
                    o_kind = K_DSH;
                end else begin
                    others = cur.pres & ~idx2oh(r_id);
                    if (others == '0) begin
                        upd_ent.st    = D_OWN;
                        upd_ent.dirty = 1'b1;
                        upd_ent.pres  = idx2oh(r_id);
                        o_mask = idx2oh(r_id);
                        o_kind = K_DEX;
                    end else begin
                        upd_ent.st   = D_WINV;
                        upd_ent.cnt  = CW'($countones(others));
                        upd_ent.who  = r_id;
                        upd_ent.wr   = 1'b1;
                        upd_ent.pres = cur.pres & ~others;
                        o_mask = others;
                        o_kind = K_INV;
                    end
                end
            end else begin
                upd_ent.st  = D_WREC;
                upd_ent.who = r_id;
                upd_ent.wr  = req_write[r_id];
                o_mask = cur.pres;
                o_kind = req_write[r_id] ? K_RCI : K_RCS;
            end
        end
    end

    coh_dir_table u_tbl (
        .clk(clk), .rst(rst),
        .upd_en(upd_en), .upd_blk(upd_blk), .upd_ent(upd_ent),
        .ent(tbl)
    );

    coh_msg_reg u_out (
        .clk(clk), .rst(rst),
        .in_mask(o_mask), .in_kind(o_kind), .in_blk(o_blk), .in_data(o_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_blk(msg_blk), .msg_data(msg_data)
    );

    assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));
    assert_ack_first_R8: assert property (@(posedge clk) disable iff (rst)
        (|ack_valid) |-> (req_ready == '0));
    assert_msg_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (|msg_valid) |-> $past((|ack_ready) || (|req_ready)));
    assert_held_R7: assert property (@(posedge clk) disable iff (rst)
        (|msg_valid) && (msg_kind[KW-1:0] == K_RCS) |-> !req_ready[0]
            || (req_blk[BW-1:0] != msg_blk[BW-1:0]) || !msg_valid[0]);
endmodule

// File: tb/coh_home_test.sv
module coh_home_test;
    localparam int P  = 4;
    localparam int BW = 2;
    localparam int DW = 8;
    localparam int KW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [P-1:0]    req_valid = '0, req_write = '0;
    logic [P*BW-1:0] req_blk = '0;
    logic [P-1:0]    req_ready;
    logic [P-1:0]    ack_valid = '0, ack_wb = '0;
    logic [P*BW-1:0] ack_blk = '0;
    logic [P*DW-1:0] ack_data = '0;
    logic [P-1:0]    ack_ready;
    logic [P-1:0]    msg_valid;
    logic [P*KW-1:0] msg_kind;
    logic [P*BW-1:0] msg_blk;
    logic [P*DW-1:0] msg_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    coh_home uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_blk(req_blk), .req_ready(req_ready),
        .ack_valid(ack_valid), .ack_wb(ack_wb), .ack_blk(ack_blk), .ack_data(ack_data),
        .ack_ready(ack_ready),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_blk(msg_blk), .msg_data(msg_data)
    );

    // port, write, block, expected kind, expected data
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 1'b0, 2'd0, 3'd1, 8'h40},
        {2'd1, 1'b0, 2'd0, 3'd1, 8'h40},
        {2'd2, 1'b0, 2'd1, 3'd1, 8'h41},
        {2'd2, 1'b1, 2'd1, 3'd2, 8'h41},
        {2'd3, 1'b0, 2'd2, 3'd1, 8'h42},
        {2'd3, 1'b1, 2'd3, 3'd2, 8'h43}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [P-1:0] mask, input int kind, input int blk,
                              input int data, input bit use_data, input string tag);
        chk(msg_valid == mask, {tag, " mask"}, msg_valid, mask);
        for (int p = 0; p < P; p++) begin
            if (mask[p]) begin
                chk(int'(msg_kind[p*KW +: KW]) == kind, {tag, " kind"}, msg_kind[p*KW +: KW], kind);
                chk(int'(msg_blk[p*BW +: BW]) == blk, {tag, " blk"}, msg_blk[p*BW +: BW], blk);
                if (use_data)
                    chk(int'(msg_data[p*DW +: DW]) == data, {tag, " data"}, msg_data[p*DW +: DW], data);
            end
        end
    endtask

    // drive one request for one cycle; report whether it was accepted
    task automatic do_req(input int p, input bit w, input int b, output bit acc);
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_write[p] = w;
        req_blk[p*BW +: BW] = BW'(b);
        #1 acc = req_ready[p];
        @(negedge clk);
        req_valid[p] = 1'b0;
    endtask

    task automatic do_ack(input int p, input bit wb, input int b, input int d);
        @(negedge clk);
        ack_valid[p] = 1'b1;
        ack_wb[p] = wb;
        ack_blk[p*BW +: BW] = BW'(b);
        ack_data[p*DW +: DW] = DW'(d);
        @(negedge clk);
        ack_valid[p] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit acc;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1: no messages after reset
        chk(msg_valid == '0, "R1 reset msg_valid", msg_valid, 0);
        chk(req_ready == '0, "R1 reset ready idle", req_ready, 0);

        // table of simple requests; R1 initial words seen via R2/R3 replies
        for (int v = 0; v < 6; v++) begin
            do_req(int'(VEC[v][15:14]), VEC[v][13], int'(VEC[v][12:11]), acc);
            chk(acc, "R8 table request accepted", acc, 1);
            expect_msg(P'(1) << VEC[v][15:14], int'(VEC[v][10:8]), int'(VEC[v][12:11]),
                       int'(VEC[v][7:0]), 1'b1, VEC[v][13] ? "R3 table exclusive" : "R2 table shared");
        end

        // R4: P2 writes blk0 shared by P0,P1 -> invalidate both, not P2
        do_req(2, 1'b1, 0, acc);
        chk(acc, "R4 write accepted", acc, 1);
        expect_msg(4'b0011, 3, 0, 0, 1'b0, "R4 invalidations");

        // R7: P3 request to blk0 held while waiting
        @(negedge clk);
        req_valid[3] = 1'b1; req_write[3] = 1'b0; req_blk[3*BW +: BW] = 2'd0;
        repeat (2) begin
            #1 chk(req_ready[3] == 1'b0, "R7 busy block held", req_ready[3], 0);
            @(negedge clk);
        end
        req_blk[3*BW +: BW] = 2'd2;
        #1 chk(req_ready[3] == 1'b1, "R7 other block proceeds", req_ready[3], 1);
        @(negedge clk);
        req_valid[3] = 1'b0;
        expect_msg(4'b1000, 1, 2, 8'h42, 1'b1, "R7 other block data");

        do_ack(0, 1'b0, 0, 0);
        expect_msg(4'b0000, 0, 0, 0, 1'b0, "R4 no grant before last ack");
        do_ack(1, 1'b0, 0, 0);
        expect_msg(4'b0100, 2, 0, 8'h40, 1'b1, "R4 grant after last ack");

        // R5: P0 reads owned blk0 (owner P2)
        do_req(0, 1'b0, 0, acc);
        chk(acc, "R5 read accepted", acc, 1);
        expect_msg(4'b0100, 4, 0, 0, 1'b0, "R5 recall shared to owner");
        do_ack(2, 1'b1, 0, 8'h77);
        expect_msg(4'b0001, 1, 0, 8'h77, 1'b1, "R5 written-back data");
        do_req(1, 1'b0, 0, acc);
        expect_msg(4'b0010, 1, 0, 8'h77, 1'b1, "R5 memory updated and clean");
        // old owner stays a sharer: P1 write invalidates P0 and P2 only
        do_req(1, 1'b1, 0, acc);
        expect_msg(4'b0101, 3, 0, 0, 1'b0, "R5 R4 owner kept as sharer");
        do_ack(2, 1'b0, 0, 0);
        do_ack(0, 1'b0, 0, 0);
        expect_msg(4'b0010, 2, 0, 8'h77, 1'b1, "R4 grant to P1");

        // R6: P0 writes blk3 owned by P3
        do_req(0, 1'b1, 3, acc);
        expect_msg(4'b1000, 5, 3, 0, 1'b0, "R6 recall invalidate");
        do_ack(3, 1'b1, 3, 8'h99);
        expect_msg(4'b0001, 2, 3, 8'h99, 1'b1, "R6 exclusive with wb data");
        do_req(3, 1'b0, 3, acc);
        expect_msg(4'b0001, 4, 3, 0, 1'b0, "R6 new owner only recalled");
        do_ack(0, 1'b1, 3, 8'h5A);
        expect_msg(4'b1000, 1, 3, 8'h5A, 1'b1, "R6 data to reader");

        // R8: two requests same cycle, lowest port first
        @(negedge clk);
        req_valid[1:0] = 2'b11; req_write[1:0] = 2'b00;
        req_blk[0 +: BW] = 2'd2; req_blk[BW +: BW] = 2'd2;
        #1 chk(req_ready == 4'b0001, "R8 lowest port wins", req_ready, 1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        expect_msg(4'b0001, 1, 2, 8'h42, 1'b1, "R8 first grant");
        #1 chk(req_ready == 4'b0010, "R8 second port next", req_ready, 2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        expect_msg(4'b0010, 1, 2, 8'h42, 1'b1, "R8 second grant");

        // R8/R9: stray ack blocks requests and yields no message
        @(negedge clk);
        req_valid[0] = 1'b1; req_write[0] = 1'b0; req_blk[0 +: BW] = 2'd2;
        ack_valid[3] = 1'b1; ack_wb[3] = 1'b0; ack_blk[3*BW +: BW] = 2'd2;
        #1 chk(req_ready == '0, "R8 ack blocks request", req_ready, 0);
        chk(ack_ready == 4'b1000, "R8 ack taken", ack_ready, 8);
        @(negedge clk);
        ack_valid[3] = 1'b0;
        expect_msg(4'b0000, 0, 0, 0, 1'b0, "R9 stray ack dropped");
        #1 chk(req_ready == 4'b0001, "R8 request after ack", req_ready, 1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        expect_msg(4'b0001, 1, 2, 8'h42, 1'b1, "R9 single pulse data");
        @(negedge clk);
        expect_msg(4'b0000, 0, 0, 0, 1'b0, "R9 pulse ends");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule